// File: doc/BRIEF.md
# Unlockable Indexed Configuration Port

This block lets a host on a byte-wide legacy I/O bus reach the configuration registers of a dual-channel disk controller. It uses two addresses inside an eight-byte window. The host writes a register number to the index port and then reads or writes that register through the data port. The window sits at 0x078 or at 0x178, chosen by a build-time parameter.

When the locking parameter is set, the port is armed for one access at a time. The host must first write the block's device ID, 0x60 plus a two-bit instance number, to the index port. After one data-port access the port locks again. When locking is off, the port stays open.

The host may issue 8-bit, 16-bit or 32-bit accesses. The block splits each one into byte accesses at consecutive addresses, lowest address first, and handles one byte per clock. The block drives the register values to downstream logic on dedicated outputs. A status flag for pending interrupts is set from outside and cleared when register 0x50 is read.

Top module: `cfg_index_port`

## Requirements
- R1: Only the 8-byte window at the selected base (0x078 when `LOW_BASE`=1, 0x178 otherwise) is decoded. The index port is window offset 0 and the data port is offset 4. A read of any other offset, or of an address outside the window, returns 0xFF, and a write there changes nothing.
- R2: A synchronous reset puts the block in configuration mode with index 0. Register 0x50 becomes 0x02 with the instance number in bits 4:3, bit 5 = `LOW_BASE` and bit 7 = `LOCK_EN`. Register 0x59 becomes 0x40 and registers 0x51..0x58 become 0.
- R3: With locking enabled and the port locked, an index-port write of exactly 0x60+`INSTANCE` enters configuration mode and keeps the stored index. Any other value is ignored.
- R4: In configuration mode an index-port write loads the index. An index-port read returns the index in configuration mode and 0xFF when locked. An index access never changes the mode.
- R5: In configuration mode a data-port access reads or writes the register selected by the index. With locking enabled the port then locks. With locking disabled it stays in configuration mode.
- R6: While locked, a data-port write is ignored and a data-port read returns 0xFF.
- R7: Write masks are applied per register:
  - Registers 0x51, 0x52, 0x54, 0x56, 0x58 and 0x59 take all 8 bits.
  - Registers 0x53 and 0x55 keep bits 7:6 only.
  - Register 0x57 keeps only the bits of mask 0xDC.
  - Register 0x50 and every other index are not writable.
  - Indices outside 0x50..0x59 read as 0x00.
- R8: A one-cycle pulse on `intSet` sets bit 2 of register 0x50. A data-port read of register 0x50 returns the old value and clears bit 2 at that clock edge. A set in the same cycle wins over the clear.
- R9: Access size and byte order:
  - `hostSize` 0 is one byte, 1 is 16 bits and 2 or 3 is 32 bits.
  - Write byte k goes to address `hostAddr`+k, and read byte k comes from `hostAddr`+k. Bytes are handled in increasing k, one per clock.
  - Read bytes not fetched, and all bytes after a write, are 0xFF.
  - `hostDone` pulses for one cycle, 2, 3 or 5 clocks after the edge that takes the request.
  - A request while `hostBusy` is high is ignored.
- R10: `cfgStatus` shows register 0x50 at all times. Byte k of `cfgRegs` shows register 0x51+k at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hostReq | input | 1 | Request strobe, taken when not busy |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| hostAddr | input | ADDR_W | I/O address of the lowest byte |
| hostWdata | input | 32 | Write data, byte k for address+k |
| hostBusy | output | 1 | Access in progress |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Assembled read data, valid from done |
| intSet | input | 1 | Sets the interrupt status flag |
| cfgStatus | output | 8 | Current value of register 0x50 |
| cfgRegs | output | 72 | Registers 0x51..0x59, byte k = 0x51+k |

## Verification
The bench builds two instances on one shared bus:
- The defaults: low base 0x078, locking off, instance 0.
- High base 0x178, locking on, instance 2, whose device ID is 0x62.

Each access therefore lands in exactly one window, and the other instance must return 0xFF. Several paths are reachable only with the locking build: the unlock with a wrong or a right ID, the relock after each data access, and the ignored locked write. The unaligned 16-bit and 32-bit accesses that straddle the window edge show which lane reaches which address. The interrupt flag test includes the same-cycle set-and-read case.

// File: rtl/cfg_index_pkg.sv
package cfg_index_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LANES     = 4;
  localparam int unsigned REG_COUNT = 9;

  localparam logic [7:0] STATUS_IDX  = 8'h50;
  localparam logic [7:0] FIRST_IDX   = 8'h51;
  localparam logic [7:0] DEV_ID_BASE = 8'h60;
  localparam logic [2:0] IDX_OFS     = 3'd0;
  localparam logic [2:0] DATA_OFS    = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic              idxLoad;
    logic              regWrite;
    logic              regRead;
    logic [BYTE_W-1:0] wrByte;
  } strobe_t;

  function automatic logic [7:0] wr_mask(input logic [7:0] idx);
    case (idx)
      8'h53, 8'h55: wr_mask = 8'hC0;
      8'h57:        wr_mask = 8'hDC;
      default:      wr_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reset_value(input logic [7:0] idx);
    reset_value = (idx == 8'h59) ? 8'h40 : 8'h00;
  endfunction

endpackage

// File: rtl/cfg_index_ctrl.sv
module cfg_index_ctrl
  import cfg_index_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter bit          LOW_BASE = 1'b1,
  parameter bit          LOCK_EN  = 1'b0,
  parameter int unsigned INSTANCE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  input  logic [7:0]        indexQ,
  input  logic [7:0]        regRdata,
  output strobe_t           str,
  output logic              hostBusy,
  output logic              hostDone,
  output logic [31:0]       hostRdata
);

  localparam logic [11:0]       BASE_FULL = LOW_BASE ? 12'h078 : 12'h178;
  localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(BASE_FULL);
  localparam logic [7:0]        DEV_ID    = DEV_ID_BASE | 8'(INSTANCE % 4);

  logic                        active;
  logic [1:0]                  byteCnt;
  logic [1:0]                  lastCnt;
  logic [1:0]                  lastNext;
  logic [ADDR_W-1:0]           addrQ;
  logic                        writeQ;
  logic [LANES-1:0][BYTE_W-1:0] wdataQ;
  logic [LANES-1:0][BYTE_W-1:0] rdataQ;
  logic                        doneQ;
  logic                        inCfg;

  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        curWbyte;
  logic              inWin;
  logic              hitIdx;
  logic              hitData;
  logic              dataOk;
  logic              unlock;
  logic [7:0]        rdByte;

  always_comb begin
    case (hostSize)
      2'd0:    lastNext = 2'd0;
      2'd1:    lastNext = 2'd1;
      default: lastNext = 2'd3;
    endcase
  end

  assign curAddr  = addrQ + ADDR_W'(byteCnt);
  assign curWbyte = wdataQ[byteCnt];
  assign inWin    = (curAddr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
  assign hitIdx   = active && inWin && (curAddr[2:0] == IDX_OFS);
  assign hitData  = active && inWin && (curAddr[2:0] == DATA_OFS);
  assign dataOk   = hitData && inCfg;
  assign unlock   = hitIdx && writeQ && !inCfg && (curWbyte == DEV_ID);

  always_comb begin
    str.idxLoad  = hitIdx && writeQ && inCfg;
    str.regWrite = dataOk && writeQ;
    str.regRead  = dataOk && !writeQ;
    str.wrByte   = curWbyte;
  end

  always_comb begin
    if (hitIdx)      rdByte = inCfg ? indexQ : 8'hFF;
    else if (dataOk) rdByte = regRdata;
    else             rdByte = 8'hFF;
  end

  // access sequencer: one byte per clock
  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      byteCnt <= '0;
      lastCnt <= '0;
      addrQ   <= '0;
      writeQ  <= 1'b0;
      wdataQ  <= '0;
      rdataQ  <= '1;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!active) begin
        if (hostReq) begin
          active  <= 1'b1;
          byteCnt <= '0;
          lastCnt <= lastNext;
          addrQ   <= hostAddr;
          writeQ  <= hostWrite;
          wdataQ  <= hostWdata;
          rdataQ  <= '1;
        end
      end else begin
        if (!writeQ) rdataQ[byteCnt] <= rdByte;
        if (byteCnt == lastCnt) begin
          active <= 1'b0;
          doneQ  <= 1'b1;
        end else begin
          byteCnt <= byteCnt + 2'd1;
        end
      end
    end
  end

  // configuration-mode flag
  always_ff @(posedge clk) begin
    if (rst)                    inCfg <= 1'b1;
    else if (unlock)            inCfg <= 1'b1;
    else if (dataOk && LOCK_EN) inCfg <= 1'b0;
  end

  assign hostBusy  = active;
  assign hostDone  = doneQ;
  assign hostRdata = rdataQ;

  // R3: a wrong ID written while locked keeps the port locked
  p_wrong_id_stays_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (hitIdx && writeQ && !inCfg && (str.wrByte != DEV_ID)) |=> !inCfg);

  // R5: with locking enabled a data read relocks the port
  p_relock_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    (LOCK_EN && str.regRead) |=> !inCfg);

  // R9: completion is a single-cycle pulse outside busy
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    hostDone |=> !hostDone);
  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    hostDone |-> !hostBusy);

  // R9: a request while busy does not disturb the access in flight
  p_req_ignored_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (hostBusy && hostReq) |=> ($stable(addrQ) && $stable(writeQ)));

endmodule

// File: rtl/cfg_index_regs.sv
module cfg_index_regs
  import cfg_index_pkg::*;
#(
  parameter bit          LOW_BASE = 1'b1,
  parameter bit          LOCK_EN  = 1'b0,
  parameter int unsigned INSTANCE = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       str,
  input  logic                          intSet,
  output logic [7:0]                    indexQ,
  output logic [7:0]                    regRdata,
  output logic [7:0]                    cfgStatus,
  output logic [REG_COUNT*BYTE_W-1:0]   cfgRegs
);

  localparam logic [1:0] INST_BITS = 2'(INSTANCE % 4);

  logic                                 intFlag;
  logic [REG_COUNT-1:0][BYTE_W-1:0]     regVal;
  logic [7:0]                           relIdx;

  always_ff @(posedge clk) begin
    if (rst)              indexQ <= 8'h00;
    else if (str.idxLoad) indexQ <= str.wrByte;
  end

  // interrupt flag: a set wins over the clear from a read
  always_ff @(posedge clk) begin
    if (rst)                                           intFlag <= 1'b0;
    else if (intSet)                                   intFlag <= 1'b1;
    else if (str.regRead && (indexQ == STATUS_IDX))    intFlag <= 1'b0;
  end

  assign cfgStatus = {LOCK_EN, 1'b0, LOW_BASE, INST_BITS, intFlag, 2'b10};

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [7:0] MY_IDX = FIRST_IDX + 8'(g);
    localparam logic [7:0] MASK   = wr_mask(MY_IDX);
    localparam logic [7:0] RSTV   = reset_value(MY_IDX);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                     q <= RSTV;
      else if (str.regWrite && (indexQ == MY_IDX)) q <= str.wrByte & MASK;
    end
    assign regVal[g] = q;

    // R7: masked-off bits never become set
    p_mask_held_r7: assert property (@(posedge clk) disable iff (rst)
      ((q & ~MASK) == 8'h00));
  end

  assign relIdx  = indexQ - FIRST_IDX;
  assign cfgRegs = regVal;

  always_comb begin
    regRdata = 8'h00;
    if (indexQ == STATUS_IDX) regRdata = cfgStatus;
    for (int k = 0; k < REG_COUNT; k++) begin
      if (relIdx == 8'(k)) regRdata = regVal[k];
    end
  end

  // R6: the register file moves only on a write strobe
  p_no_write_no_change_r6: assert property (@(posedge clk) disable iff (rst)
    !str.regWrite |=> $stable(regVal));

  // R8: reading register 0x50 without a new set clears the flag
  p_read_clears_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (str.regRead && (indexQ == STATUS_IDX) && !intSet) |=> !cfgStatus[2]);

  // R8: a set pulse always leaves the flag raised
  p_set_raises_flag_r8: assert property (@(posedge clk) disable iff (rst)
    intSet |=> cfgStatus[2]);

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_index_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter bit          LOW_BASE = 1'b1,
  parameter bit          LOCK_EN  = 1'b0,
  parameter int unsigned INSTANCE = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hostReq,
  input  logic                        hostWrite,
  input  logic [1:0]                  hostSize,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [31:0]                 hostWdata,
  output logic                        hostBusy,
  output logic                        hostDone,
  output logic [31:0]                 hostRdata,
  input  logic                        intSet,
  output logic [7:0]                  cfgStatus,
  output logic [REG_COUNT*BYTE_W-1:0] cfgRegs
);

  strobe_t    str;
  logic [7:0] indexQ;
  logic [7:0] regRdata;

  cfg_index_ctrl #(
    .ADDR_W  (ADDR_W),
    .LOW_BASE(LOW_BASE),
    .LOCK_EN (LOCK_EN),
    .INSTANCE(INSTANCE)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hostSize (hostSize),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .indexQ   (indexQ),
    .regRdata (regRdata),
    .str      (str),
    .hostBusy (hostBusy),
    .hostDone (hostDone),
    .hostRdata(hostRdata)
  );

  cfg_index_regs #(
    .LOW_BASE(LOW_BASE),
    .LOCK_EN (LOCK_EN),
    .INSTANCE(INSTANCE)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .str      (str),
    .intSet   (intSet),
    .indexQ   (indexQ),
    .regRdata (regRdata),
    .cfgStatus(cfgStatus),
    .cfgRegs  (cfgRegs)
  );

endmodule

// File: tb/test_cfg_index_port.sv
`timescale 1ns/100ps
module test_cfg_index_port;
  import cfg_index_pkg::*;

  localparam logic [31:0] F32 = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [1:0]  hostSize = 2'd0;
  logic [9:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        intSetA = 1'b0;
  logic        busyA, doneA, busyB, doneB;
  logic [31:0] rdA, rdB;
  logic [7:0]  statA, statB;
  logic [71:0] regsA, regsB;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  // default build: base 0x078, no locking, instance 0
  cfg_index_port i_cfg_index_port (
    .clk(clk), .rst(rst), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostSize(hostSize), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostBusy(busyA), .hostDone(doneA), .hostRdata(rdA),
    .intSet(intSetA), .cfgStatus(statA), .cfgRegs(regsA));

  // locking build: base 0x178, instance 2 (ID 0x62)
  cfg_index_port #(.LOW_BASE(1'b0), .LOCK_EN(1'b1), .INSTANCE(2)) i_cfg_index_port_lk (
    .clk(clk), .rst(rst), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostSize(hostSize), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostBusy(busyB), .hostDone(doneB), .hostRdata(rdB),
    .intSet(1'b0), .cfgStatus(statB), .cfgRegs(regsB));

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [9:0]  addr;
    logic [31:0] wd;
    logic [31:0] expA;
    logic [31:0] expB;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 10'h078, 32'h00, 32'hFFFFFF00, F32,          4'd4}, // R4 index read
    '{1'b0, 2'd0, 10'h178, 32'h00, F32,          32'hFFFFFF00, 4'd4},
    '{1'b1, 2'd0, 10'h078, 32'h50, F32,          F32,          4'd4},
    '{1'b0, 2'd0, 10'h07C, 32'h00, 32'hFFFFFF22, F32,          4'd2}, // R2 status A
    '{1'b1, 2'd0, 10'h178, 32'h50, F32,          F32,          4'd4},
    '{1'b0, 2'd0, 10'h17C, 32'h00, F32,          32'hFFFFFF92, 4'd2}, // R2 status B, relocks
    '{1'b0, 2'd0, 10'h178, 32'h00, F32,          F32,          4'd4}, // locked index read
    '{1'b0, 2'd0, 10'h17C, 32'h00, F32,          F32,          4'd6}, // R6 locked data read
    '{1'b1, 2'd0, 10'h178, 32'h61, F32,          F32,          4'd3}, // R3 wrong ID
    '{1'b0, 2'd0, 10'h178, 32'h00, F32,          F32,          4'd3},
    '{1'b1, 2'd0, 10'h178, 32'h62, F32,          F32,          4'd3}, // right ID
    '{1'b0, 2'd0, 10'h178, 32'h00, F32,          32'hFFFFFF50, 4'd3}, // index kept
    '{1'b1, 2'd0, 10'h178, 32'h57, F32,          F32,          4'd4},
    '{1'b1, 2'd0, 10'h17C, 32'hFF, F32,          F32,          4'd7},
    '{1'b1, 2'd0, 10'h17C, 32'h00, F32,          F32,          4'd6}, // locked write
    '{1'b1, 2'd0, 10'h178, 32'h62, F32,          F32,          4'd3},
    '{1'b0, 2'd0, 10'h17C, 32'h00, F32,          32'hFFFFFFDC, 4'd7}, // R7 0x57 mask
    '{1'b1, 2'd0, 10'h078, 32'h53, F32,          F32,          4'd4},
    '{1'b1, 2'd0, 10'h07C, 32'hFF, F32,          F32,          4'd7},
    '{1'b0, 2'd0, 10'h07C, 32'h00, 32'hFFFFFFC0, F32,          4'd7}, // R7 0x53 mask
    '{1'b0, 2'd0, 10'h078, 32'h00, 32'hFFFFFF53, F32,          4'd5}, // R5 no relock
    '{1'b1, 2'd1, 10'h078, 32'h0055, F32,        F32,          4'd9}, // R9 16-bit
    '{1'b1, 2'd2, 10'h07C, 32'h11223344, F32,    F32,          4'd9}, // R9 32-bit
    '{1'b0, 2'd2, 10'h078, 32'h00, 32'hFFFFFF55, F32,          4'd9},
    '{1'b0, 2'd1, 10'h07C, 32'h00, 32'hFFFFFF40, F32,          4'd9},
    '{1'b1, 2'd2, 10'h175, 32'h62000000, F32,    F32,          4'd9}, // lane 3 unlocks
    '{1'b1, 2'd1, 10'h177, 32'h00005200, F32,    F32,          4'd9}, // lane 1 index
    '{1'b1, 2'd2, 10'h179, 32'hA5000000, F32,    F32,          4'd9},
    '{1'b1, 2'd0, 10'h178, 32'h62, F32,          F32,          4'd3},
    '{1'b0, 2'd2, 10'h179, 32'h00, F32,          32'hA5FFFFFF, 4'd9}, // R9 lane 3 read
    '{1'b0, 2'd2, 10'h175, 32'h00, F32,          F32,          4'd6},
    '{1'b0, 2'd0, 10'h07A, 32'h00, F32,          F32,          4'd1}, // R1 unused offset
    '{1'b1, 2'd0, 10'h07B, 32'h10, F32,          F32,          4'd1},
    '{1'b0, 2'd0, 10'h078, 32'h00, 32'hFFFFFF55, F32,          4'd1},
    '{1'b1, 2'd0, 10'h078, 32'h10, F32,          F32,          4'd7},
    '{1'b0, 2'd0, 10'h07C, 32'h00, 32'hFFFFFF00, F32,          4'd7}, // out of range
    '{1'b1, 2'd0, 10'h078, 32'h50, F32,          F32,          4'd7},
    '{1'b1, 2'd0, 10'h07C, 32'hFF, F32,          F32,          4'd7},
    '{1'b0, 2'd0, 10'h07C, 32'h00, 32'hFFFFFF22, F32,          4'd7}, // 0x50 read-only
    '{1'b1, 2'd0, 10'h078, 32'h59, F32,          F32,          4'd2},
    '{1'b0, 2'd0, 10'h07C, 32'h00, 32'hFFFFFF40, F32,          4'd2}, // 0x59 reset
    '{1'b1, 2'd0, 10'h07C, 32'h3C, F32,          F32,          4'd7},
    '{1'b0, 2'd0, 10'h07C, 32'h00, 32'hFFFFFF3C, F32,          4'd7},
    '{1'b1, 2'd0, 10'h078, 32'h51, F32,          F32,          4'd7},
    '{1'b1, 2'd0, 10'h07C, 32'h81, F32,          F32,          4'd7},
    '{1'b0, 2'd0, 10'h07C, 32'h00, 32'hFFFFFF81, F32,          4'd7}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [9:0] addr,
                        input logic [31:0] wd, output int cycles);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostSize = sz; hostAddr = addr; hostWdata = wd;
    @(posedge clk);
    @(negedge clk);
    hostReq = 1'b0;
    cycles = 1;
    while (!doneA) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    int c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2 reset state, R10 exported values
    check("R2 status A reset", statA, 8'h22);
    check("R2 status B reset", statB, 8'h92);
    check("R10 regs A reset", regsA, {8'h40, 64'h0});
    check("R10 regs B reset", regsB, {8'h40, 64'h0});
    check("R9 idle after reset", {busyA, doneA}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].wd, c);
      check($sformatf("R%0d vec %0d dut A", VEC[i].req, i), rdA, VEC[i].expA);
      check($sformatf("R%0d vec %0d dut B", VEC[i].req, i), rdB, VEC[i].expB);
    end

    // R10 exported registers after the table
    check("R10 regs A", regsA, {8'h3C, 8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 8'hC0, 8'h00, 8'h81});
    check("R10 regs B", regsB, {8'h40, 8'h00, 8'hDC, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h00});

    // R9 latency per size (index of A is 0x51)
    access(1'b0, 2'd0, 10'h078, 32'h0, c);
    check("R9 byte latency", c, 2);
    access(1'b0, 2'd1, 10'h078, 32'h0, c);
    check("R9 half latency", c, 3);
    access(1'b0, 2'd2, 10'h078, 32'h0, c);
    check("R9 word latency", c, 5);
    check("R9 word read data", rdA, 32'hFFFFFF51);

    // R9 request while busy is ignored
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostSize = 2'd2; hostAddr = 10'h078;
    @(posedge clk);
    @(negedge clk);
    hostWrite = 1'b1; hostSize = 2'd0; hostWdata = 32'h11;
    @(posedge clk);
    @(negedge clk);
    hostReq = 1'b0;
    while (!doneA) begin
      @(posedge clk);
      @(negedge clk);
    end
    access(1'b0, 2'd0, 10'h078, 32'h0, c);
    check("R9 busy request ignored", rdA, 32'hFFFFFF51);

    // R8 interrupt flag
    access(1'b1, 2'd0, 10'h078, 32'h50, c);
    @(negedge clk); intSetA = 1'b1;
    @(negedge clk); intSetA = 1'b0;
    check("R8 flag set", statA, 8'h26);
    access(1'b0, 2'd0, 10'h07C, 32'h0, c);
    check("R8 read returns flag", rdA, 32'hFFFFFF26);
    check("R8 read clears flag", statA, 8'h22);
    @(negedge clk); intSetA = 1'b1;
    @(negedge clk); intSetA = 1'b0;
    // same-cycle set and read: set wins
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostSize = 2'd0; hostAddr = 10'h07C;
    @(posedge clk);
    @(negedge clk);
    hostReq = 1'b0; intSetA = 1'b1;
    @(posedge clk);
    @(negedge clk);
    intSetA = 1'b0;
    check("R8 same-cycle done", doneA, 1'b1);
    check("R8 same-cycle read data", rdA, 32'hFFFFFF26);
    check("R8 set wins over clear", statA, 8'h26);
    access(1'b0, 2'd0, 10'h07C, 32'h0, c);
    check("R8 later read clears", statA, 8'h22);

    // R2 reset in mid-run
    access(1'b1, 2'd0, 10'h178, 32'h62, c);
    access(1'b1, 2'd0, 10'h178, 32'h53, c);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R2 regs A after reset", regsA, {8'h40, 64'h0});
    check("R2 status A after reset", statA, 8'h22);
    access(1'b0, 2'd0, 10'h178, 32'h0, c);
    check("R2 B in config with index 0", rdB, 32'hFFFFFF00);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule